// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is the control core of a boundary-scan port. It runs the standard sixteen-state test controller from TCK and TMS and holds a 10-bit instruction register. A decoder turns the active instruction into three things: a choice of data register for the scan path between TDI and TDO, a pin-control mode for the chip's I/O, and a one-shot reconfiguration request.

Three scan registers are held inside the block: a one-bit pass-through stage, a 32-bit device identifier and a 32-bit user word. Two further registers are reached through their serial return inputs: the boundary cells and an error-message register. For these the block provides select lines and capture, shift and update strobes. The boundary cells and the pad drivers are not part of this block.

When the controller is in Test-Logic-Reset, the device-identifier instruction is loaded. Scanning the data path straight after reset therefore returns the identifier.

Top module: `jtag_tap_decoder`

## Requirements
- R1: Holding trst_n low at a rising TCK edge puts the controller in Test-Logic-Reset. After the next falling edge, the device-identifier instruction is active, pin_mode is 0 (normal), bsr_sel, emr_sel, reconfig_req and tdo_oe are all low.
- R2: With no instruction loaded since reset, a data scan shifts out IDCODE_VALUE, least significant bit first, over 32 bits.
- R3: TDO changes on the falling edge of TCK. tdo_oe is high only while the controller is in Shift-IR or Shift-DR, and it is low in Run-Test/Idle.
- R4: An instruction scan shifts out the captured value 10'b0000000001, least significant bit first. A new instruction takes effect on the falling edge of TCK in Update-IR: at the rising edge that enters Update-IR, pin_mode still shows the previous mode.
- R5: Opcode 0x3FF selects the one-bit pass stage. A data scan returns 0 for the first bit, then each TDI bit one TCK later.
- R6: Any opcode not listed in these requirements acts exactly like 0x3FF, with pin_mode 0.
- R7: Opcode 0x00B sets pin_mode to 2 (all outputs high-impedance) and uses the pass stage. pin_mode stays 2 across data scans until another instruction is loaded or Test-Logic-Reset is entered.
- R8: Opcode 0x00A sets pin_mode to 3 (hold pins at the update-stage values) and uses the pass stage.
- R9: Opcode 0x007 scans out the 32-bit usercode input as sampled in Capture-DR, least significant bit first.
- R10: Opcodes 0x00F, 0x08F and 0x04F set pin_mode to 1 (drive from the update stage) and bsr_sel high. Opcode 0x005 sets bsr_sel high with pin_mode 0. While bsr_sel is high, TDO carries bsr_so and dr_shift is high in Shift-DR. bsr_sel and emr_sel are never both high.
- R11: Opcode 0x001 raises reconfig_req for exactly one TCK period, starting at the falling edge in Update-IR. It uses the pass stage with pin_mode 0.
- R12: Opcode 0x017 sets emr_sel high and bsr_sel low. TDO then carries emr_so, with pin_mode 0.
- R13: Five TCK cycles with TMS high, from any state, reach Test-Logic-Reset. That restores the device-identifier instruction and pin_mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| usercode | input | 32 | User word captured by the user-code instruction |
| bsr_so | input | 1 | Serial return from the boundary cells |
| emr_so | input | 1 | Serial return from the error-message register |
| tdo | output | 1 | Serial test data out, valid when tdo_oe is high |
| tdo_oe | output | 1 | TDO drive enable; low means high-impedance |
| dr_capture | output | 1 | Controller is in Capture-DR |
| dr_shift | output | 1 | Controller is in Shift-DR |
| dr_update | output | 1 | Controller is in Update-DR |
| bsr_sel | output | 1 | Boundary cells form the data path |
| emr_sel | output | 1 | Error-message register forms the data path |
| pin_mode | output | 2 | 0 normal, 1 external test, 2 high-impedance, 3 clamp |
| reconfig_req | output | 1 | One-TCK reconfiguration request |

## Verification
The bench looks at when a new instruction takes effect. A design that applies the instruction on the rising edge would show the new pin mode one half-cycle early. A design that skips the reload in Test-Logic-Reset would return the last user instruction's data instead of the identifier. Unknown opcodes and the three opcodes that share the pass stage are checked for the leading zero and the one-cycle delay; an off-by-one path length shifts the whole returned word. The external paths are driven with complementary patterns, so a swapped select shows up, and the high-impedance mode is checked again after a data scan to catch a mode that clears itself on the next update.

// File: rtl/jtag_tap_pkg.sv
// Package: shared types, opcodes and the instruction decode function for
// the boundary-scan port. Assumes a 10-bit instruction register.
package jtag_tap_pkg;

    localparam int IR_W = 10;

    // Controller states (standard sixteen-state test controller)
    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    // Data register placed in the scan path
    typedef enum logic [2:0] {
        DR_PASS, DR_DEVID, DR_USER, DR_BSC, DR_ERRMSG
    } dr_sel_t;

    // Pin-control mode presented to the I/O ring
    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_EXTEST = 2'd1,
        PM_HIGHZ  = 2'd2,
        PM_CLAMP  = 2'd3
    } pin_mode_t;

    typedef struct packed {
        dr_sel_t   dr;
        pin_mode_t pins;
        logic      reconf;
    } insn_ctl_t;

    // Opcodes
    localparam logic [IR_W-1:0] OP_SNAP      = 10'h005;
    localparam logic [IR_W-1:0] OP_EXT_DRIVE = 10'h00F;
    localparam logic [IR_W-1:0] OP_EXT_PULSE = 10'h08F;
    localparam logic [IR_W-1:0] OP_EXT_TRAIN = 10'h04F;
    localparam logic [IR_W-1:0] OP_PASS      = 10'h3FF;
    localparam logic [IR_W-1:0] OP_USER      = 10'h007;
    localparam logic [IR_W-1:0] OP_DEVID     = 10'h006;
    localparam logic [IR_W-1:0] OP_FLOAT     = 10'h00B;
    localparam logic [IR_W-1:0] OP_HOLD      = 10'h00A;
    localparam logic [IR_W-1:0] OP_RECONF    = 10'h001;
    localparam logic [IR_W-1:0] OP_ERRMSG    = 10'h017;

    // Value loaded into the instruction shift stage in Capture-IR
    localparam logic [IR_W-1:0] IR_CAPTURE = 10'b00_0000_0001;

    // Map an opcode to its data-register choice, pin mode and request flag
    function automatic insn_ctl_t decode_insn(input logic [IR_W-1:0] op);
        insn_ctl_t c;
        c.dr     = DR_PASS;
        c.pins   = PM_NORMAL;
        c.reconf = 1'b0;
        case (op)
            OP_SNAP:      c.dr = DR_BSC;
            OP_EXT_DRIVE,
            OP_EXT_PULSE,
            OP_EXT_TRAIN: begin
                c.dr   = DR_BSC;
                c.pins = PM_EXTEST;
            end
            OP_USER:      c.dr = DR_USER;
            OP_DEVID:     c.dr = DR_DEVID;
            OP_FLOAT:     c.pins = PM_HIGHZ;
            OP_HOLD:      c.pins = PM_CLAMP;
            OP_RECONF:    c.reconf = 1'b1;
            OP_ERRMSG:    c.dr = DR_ERRMSG;
            default:      c.dr = DR_PASS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
// Module: test controller state machine.
// Advances on rising TCK under TMS; a low rst_n at a rising edge forces
// Test-Logic-Reset. Assumes rst_n is synchronous to TCK.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state selection from the current state and TMS
    always_comb begin
        nxt = state;
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_TLR;
        else        state <= nxt;
    end

    // R13
    tlr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_TLR && tms) |=> (state == ST_TLR));

    // R13
    sel_ir_escape_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_SEL_IR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/jtag_tap_ir.sv
// Module: instruction register and decoder.
// Shift stage runs on rising TCK; the active instruction loads on falling
// TCK in Update-IR and is forced to the device-ID opcode in Test-Logic-Reset.
// Assumes state comes from the rising-edge controller.
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_t state,
    input  logic       tdi,
    output logic       ir_so,
    output insn_ctl_t  ctl,
    output logic       reconf_req
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_act;
    logic            upd_q;

    // Instruction shift stage: capture fixed pattern, then shift LSB first
    always_ff @(posedge tck) begin
        if (!rst_n)                   ir_sh <= IR_CAPTURE;
        else if (state == ST_CAP_IR)  ir_sh <= IR_CAPTURE;
        else if (state == ST_SHF_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Active instruction: reload on reset state, take new value in Update-IR
    always_ff @(negedge tck) begin
        if (!rst_n || state == ST_TLR) begin
            ir_act <= OP_DEVID;
            upd_q  <= 1'b0;
        end else if (state == ST_UPD_IR) begin
            ir_act <= ir_sh;
            upd_q  <= 1'b1;
        end else begin
            upd_q  <= 1'b0;
        end
    end

    // Decode the active instruction
    always_comb ctl = decode_insn(ir_act);

    // One-period request following an update that loaded the reconfig opcode
    assign reconf_req = upd_q & ctl.reconf;
    assign ir_so      = ir_sh[0];

    // R1
    tlr_loads_devid_chk: assert property (@(negedge tck) disable iff (!rst_n)
        (state == ST_TLR) |=> (ctl.dr == DR_DEVID && ctl.pins == PM_NORMAL));

    // R7
    highz_sticky_chk: assert property (@(negedge tck) disable iff (!rst_n)
        (ctl.pins == PM_HIGHZ && state != ST_UPD_IR && state != ST_TLR)
        |=> (ctl.pins == PM_HIGHZ));

    // R11
    reconf_single_chk: assert property (@(negedge tck) disable iff (!rst_n)
        reconf_req |=> !reconf_req);

endmodule

// File: rtl/jtag_tap_dr.sv
// Module: internal data registers and the TDO output stage.
// Holds the pass stage, device ID and user word; chooses the serial source
// by the decoded selection and retimes it onto falling TCK.
// Assumes external registers present their serial bit on bsr_so / emr_so.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int               DEVID_W      = 32,
    parameter int               USER_W       = 32,
    parameter logic [DEVID_W-1:0] IDCODE_VALUE = '0
) (
    input  logic              tck,
    input  logic              rst_n,
    input  tap_state_t        state,
    input  logic              tdi,
    input  dr_sel_t           dr_sel,
    input  logic [USER_W-1:0] usercode,
    input  logic              ir_so,
    input  logic              bsr_so,
    input  logic              emr_so,
    output logic              tdo,
    output logic              tdo_oe
);

    logic               pass_q;
    logic [DEVID_W-1:0] devid_sh;
    logic [USER_W-1:0]  user_sh;
    logic               dr_bit;
    logic               in_shift;

    // Pass stage: captures 0, shifts one bit
    always_ff @(posedge tck) begin
        if (!rst_n)                                        pass_q <= 1'b0;
        else if (state == ST_CAP_DR)                       pass_q <= 1'b0;
        else if (state == ST_SHF_DR && dr_sel == DR_PASS)  pass_q <= tdi;
    end

    // Device ID register: captures the constant, shifts LSB first
    always_ff @(posedge tck) begin
        if (!rst_n)                                         devid_sh <= IDCODE_VALUE;
        else if (state == ST_CAP_DR)                        devid_sh <= IDCODE_VALUE;
        else if (state == ST_SHF_DR && dr_sel == DR_DEVID)  devid_sh <= {tdi, devid_sh[DEVID_W-1:1]};
    end

    // User word register: samples the input at capture, shifts LSB first
    always_ff @(posedge tck) begin
        if (!rst_n)                                        user_sh <= '0;
        else if (state == ST_CAP_DR)                       user_sh <= usercode;
        else if (state == ST_SHF_DR && dr_sel == DR_USER)  user_sh <= {tdi, user_sh[USER_W-1:1]};
    end

    // Serial source for the selected data register
    always_comb begin
        case (dr_sel)
            DR_DEVID:  dr_bit = devid_sh[0];
            DR_USER:   dr_bit = user_sh[0];
            DR_BSC:    dr_bit = bsr_so;
            DR_ERRMSG: dr_bit = emr_so;
            default:   dr_bit = pass_q;
        endcase
    end

    assign in_shift = (state == ST_SHF_DR) || (state == ST_SHF_IR);

    // Output stage retimed to the falling edge
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == ST_SHF_IR) ? ir_so : dr_bit;
            tdo_oe <= in_shift;
        end
    end

    // R3
    tdo_oe_shift_only_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (state == ST_SHF_DR || state == ST_SHF_IR));

    // R5
    pass_capture_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR) |=> (pass_q == 1'b0));

endmodule

// File: rtl/jtag_tap_decoder.sv
// Module: top of the boundary-scan port.
// Ties the controller, instruction register/decoder and data-register path
// together, and exposes pin-mode, path selects and data-register strobes.
// Assumes trst_n (when used) is synchronous to TCK.
module jtag_tap_decoder
    import jtag_tap_pkg::*;
#(
    parameter bit          USE_TRST     = 1'b1,
    parameter int          DEVID_W      = 32,
    parameter int          USER_W       = 32,
    parameter logic [31:0] IDCODE_VALUE = 32'h1A2B_C0DD
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [USER_W-1:0] usercode,
    input  logic              bsr_so,
    input  logic              emr_so,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              dr_capture,
    output logic              dr_shift,
    output logic              dr_update,
    output logic              bsr_sel,
    output logic              emr_sel,
    output logic [1:0]        pin_mode,
    output logic              reconfig_req
);

    logic       rst_n;
    tap_state_t state;
    insn_ctl_t  ctl;
    logic       ir_so;

    // Reset source: the test reset pin, or none when it is not bonded out
    generate
        if (USE_TRST) begin : g_trst
            assign rst_n = trst_n;
        end else begin : g_no_trst
            assign rst_n = 1'b1;
        end
    endgenerate

    jtag_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    jtag_tap_ir u_ir (
        .tck        (tck),
        .rst_n      (rst_n),
        .state      (state),
        .tdi        (tdi),
        .ir_so      (ir_so),
        .ctl        (ctl),
        .reconf_req (reconfig_req)
    );

    jtag_tap_dr #(
        .DEVID_W      (DEVID_W),
        .USER_W       (USER_W),
        .IDCODE_VALUE (IDCODE_VALUE[DEVID_W-1:0])
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .state    (state),
        .tdi      (tdi),
        .dr_sel   (ctl.dr),
        .usercode (usercode),
        .ir_so    (ir_so),
        .bsr_so   (bsr_so),
        .emr_so   (emr_so),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe)
    );

    // Strobes and selects for the external data registers
    assign dr_capture = (state == ST_CAP_DR);
    assign dr_shift   = (state == ST_SHF_DR);
    assign dr_update  = (state == ST_UPD_DR);
    assign bsr_sel    = (ctl.dr == DR_BSC);
    assign emr_sel    = (ctl.dr == DR_ERRMSG);
    assign pin_mode   = ctl.pins;

    // R10
    ext_path_onehot_chk: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({bsr_sel, emr_sel}));

    // R10
    extest_selects_bsc_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (pin_mode == 2'd1) |-> bsr_sel);

endmodule

// File: tb/jtag_tap_decoder_tb.sv
module jtag_tap_decoder_tb_top;

    localparam logic [31:0] IDV = 32'h1A2B_C0DD;

    logic        tck = 1'b0;
    logic        trst_n, tms, tdi, side;
    logic [31:0] usercode;
    logic        tdo, tdo_oe, dr_capture, dr_shift, dr_update;
    logic        bsr_sel, emr_sel, reconfig_req;
    logic [1:0]  pin_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [1:0] pre_pins;
    bit         oe_all;
    bit         shift_all;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } sb_item_t;

    sb_item_t    exp_q[$];
    logic [31:0] act_q[$];
    event        sb_ev;

    always #5 tck = ~tck;

    jtag_tap_decoder #(.IDCODE_VALUE(IDV)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .usercode(usercode), .bsr_so(side), .emr_so(~side),
        .tdo(tdo), .tdo_oe(tdo_oe), .dr_capture(dr_capture),
        .dr_shift(dr_shift), .dr_update(dr_update),
        .bsr_sel(bsr_sel), .emr_sel(emr_sel), .pin_mode(pin_mode),
        .reconfig_req(reconfig_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Scoreboard: expected words queued by the driver, actual words compared by the monitor
    task automatic sb_expect(input logic [31:0] v, input string tag);
        sb_item_t it;
        it.v = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin
        forever begin
            @(sb_ev);
            while (act_q.size() > 0) begin
                sb_item_t e;
                logic [31:0] a;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                chk(e.tag, a, e.v);
            end
        end
    end

    // One TCK step: sample TDO after the falling edge, then drive the next inputs
    task automatic step(input logic t, input logic d, input logic s, output logic o);
        @(negedge tck);
        #1;
        o = tdo;
        tms = t;
        tdi = d;
        side = s;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, o);
    endtask

    // Data scan from Run-Test/Idle, back to Run-Test/Idle
    task automatic dr_scan(input int n, input logic [31:0] din, input logic [31:0] sp);
        logic o;
        logic [31:0] got;
        got = '0;
        oe_all = 1;
        shift_all = 1;
        step(1'b1, 1'b0, 1'b0, o);
        step(1'b0, 1'b0, 1'b0, o);
        step(1'b0, 1'b0, sp[0], o);
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            #1;
            got[i] = tdo;
            if (!tdo_oe) oe_all = 0;
            if (!dr_shift) shift_all = 0;
            tms = (i == n - 1);
            tdi = din[i];
            side = (i + 1 < 32) ? sp[i+1] : 1'b0;
        end
        step(1'b1, 1'b0, 1'b0, o);
        step(1'b0, 1'b0, 1'b0, o);
        act_q.push_back(got);
        ->sb_ev;
        #0;
    endtask

    // Instruction scan from Run-Test/Idle; records pin_mode at the Update-IR rising edge
    task automatic ir_scan(input logic [9:0] op, output logic [9:0] got);
        logic o;
        got = '0;
        step(1'b1, 1'b0, 1'b0, o);
        step(1'b1, 1'b0, 1'b0, o);
        step(1'b0, 1'b0, 1'b0, o);
        step(1'b0, 1'b0, 1'b0, o);
        for (int i = 0; i < 10; i++) begin
            @(negedge tck);
            #1;
            got[i] = tdo;
            tms = (i == 9);
            tdi = op[i];
        end
        step(1'b1, 1'b0, 1'b0, o);
        @(posedge tck);
        #1;
        pre_pins = pin_mode;
        step(1'b0, 1'b0, 1'b0, o);
    endtask

    task automatic load(input logic [9:0] op);
        logic [9:0] g;
        ir_scan(op, g);
    endtask

    task automatic pass_scan(input string tag);
        logic [31:0] din;
        din = 32'h0000_01B6;
        sb_expect({23'd0, din[7:0], 1'b0}, tag);
        dr_scan(9, din, 32'h0);
    endtask

    initial begin
        logic [9:0] irg;
        logic o;
        trst_n = 0; tms = 1; tdi = 0; side = 0;
        usercode = 32'hCAFE_1234;
        repeat (3) @(posedge tck);
        @(negedge tck);
        #1;
        // R1 reset state
        chk("R1 pin_mode", {30'd0, pin_mode}, 32'd0);
        chk("R1 selects/oe/req", {28'd0, bsr_sel, emr_sel, reconfig_req, tdo_oe}, 32'd0);
        trst_n = 1;
        step(1'b0, 1'b0, 1'b0, o);
        idle(2);
        // R3 TDO disabled in Run-Test/Idle
        chk("R3 tdo_oe idle", {31'd0, tdo_oe}, 32'd0);

        // R2 device ID straight after reset
        sb_expect(IDV, "R2 idcode after reset");
        dr_scan(32, 32'h0, 32'h0);
        chk("R3 tdo_oe during shift", {31'd0, oe_all}, 32'd1);

        // R4 captured instruction pattern, R5 pass stage
        ir_scan(10'h3FF, irg);
        chk("R4 ir capture", {22'd0, irg}, 32'h001);
        pass_scan("R5 bypass path");

        // R7 high-impedance mode and R4 update timing
        load(10'h00B);
        chk("R4 pins unchanged at update rising edge", {30'd0, pre_pins}, 32'd0);
        chk("R7 highz mode", {30'd0, pin_mode}, 32'd2);
        pass_scan("R7 highz bypass path");
        chk("R7 highz sticky after scan", {30'd0, pin_mode}, 32'd2);

        // R8 clamp
        load(10'h00A);
        chk("R4 old mode before falling edge", {30'd0, pre_pins}, 32'd2);
        chk("R8 clamp mode", {30'd0, pin_mode}, 32'd3);
        pass_scan("R8 clamp bypass path");

        // R6 unrecognised opcodes
        load(10'h123);
        chk("R6 unknown pins", {30'd0, pin_mode}, 32'd0);
        pass_scan("R6 unknown 0x123 path");
        load(10'h2A5);
        pass_scan("R6 unknown 0x2A5 path");

        // R9 user word
        load(10'h007);
        sb_expect(32'hCAFE_1234, "R9 usercode");
        dr_scan(32, 32'h0, 32'h0);
        usercode = 32'h0BAD_F00D;
        sb_expect(32'h0BAD_F00D, "R9 usercode resampled");
        dr_scan(32, 32'hFFFF_FFFF, 32'h0);

        // R10 external test opcodes and sample
        load(10'h00F);
        chk("R10 extest pins", {30'd0, pin_mode}, 32'd1);
        chk("R10 extest bsr_sel", {30'd0, bsr_sel, emr_sel}, 32'd2);
        sb_expect(32'h5A, "R10 bsr path");
        dr_scan(8, 32'h0, 32'h5A);
        chk("R10 dr_shift in Shift-DR", {31'd0, shift_all}, 32'd1);
        load(10'h08F);
        chk("R10 ac pulse pins", {29'd0, bsr_sel, pin_mode}, 32'd5);
        load(10'h04F);
        chk("R10 ac train pins", {29'd0, bsr_sel, pin_mode}, 32'd5);
        load(10'h005);
        chk("R10 sample pins normal", {29'd0, bsr_sel, pin_mode}, 32'd4);
        sb_expect(32'hC3, "R10 sample bsr path");
        dr_scan(8, 32'h0, 32'hC3);

        // R12 error-message register
        load(10'h017);
        chk("R12 emr select", {28'd0, bsr_sel, emr_sel, pin_mode}, 32'd4);
        sb_expect(32'hA5 ^ 32'hFF, "R12 emr path");
        dr_scan(8, 32'h0, 32'hA5);

        // R11 reconfiguration pulse
        load(10'h001);
        chk("R11 reconfig high after update", {31'd0, reconfig_req}, 32'd1);
        step(1'b0, 1'b0, 1'b0, o);
        chk("R11 reconfig one period", {31'd0, reconfig_req}, 32'd0);
        chk("R11 pins normal", {30'd0, pin_mode}, 32'd0);
        pass_scan("R11 bypass path");

        // R13 five TMS-high cycles restore device ID
        load(10'h00B);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, o);
        step(1'b0, 1'b0, 1'b0, o);
        chk("R13 pins normal after reset path", {30'd0, pin_mode}, 32'd0);
        sb_expect(IDV, "R13 idcode after tms reset");
        dr_scan(32, 32'h0, 32'h0);

        // R1 test reset mid-run
        load(10'h007);
        @(negedge tck);
        #1 trst_n = 0;
        @(negedge tck);
        #1 trst_n = 1;
        step(1'b0, 1'b0, 1'b0, o);
        sb_expect(IDV, "R1 idcode after trst");
        dr_scan(32, 32'h0, 32'h0);

        ->sb_ev;
        #1;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule